// File: doc/BRIEF.md
# Quad-Modulus Prescaler Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It takes a requested total division `nReq` and a prescaler select `presSel`, and it produces one pulse for the phase detector every `nReq` input clock cycles. Internally the ratio is not counted by one modulo-N counter. It is split into three counter loads, A, B and C, that satisfy N = P·C + 4·B + A. Here P is the prescaler base (16 or 32), C = floor(N / P), A = N mod 4 and B = floor((N − P·C) / 4). C is 6 bits wide, B is 3 bits wide and A is 2 bits wide.

The counters run one after the other in each period. First the A phase runs, with the prescaler extended by one input cycle per A count. Next the B phase runs, extended by four input cycles per B count. Last the C phase runs, with C prescaler periods of P input cycles each. A phase whose load is zero is skipped. The modulus-control lines show which phase is active.

A new ratio or prescaler setting is taken only at the end of a period. If the request is illegal, the flag `cfgInvalid` rises and the divider stops emitting pulses after the current period ends. It starts again on the first clock edge at which a legal request is present.

Top module: `qm_divider`

## Requirements
- R1: For a legal request, `divPulse` rises once every N input cycles. The prescaler base is P = 16 when `presSel` = 0 and P = 32 when `presSel` = 1.
- R2: Each period has three phases, in this order. First, A cycles with `modCtrl` = 2'b01, where A = N mod 4. Then 4·B cycles with `modCtrl` = 2'b10, where B = floor((N − P·C)/4). Then P·C cycles with `modCtrl` = 2'b00, where C = floor(N/P). `modCtrl` never has both bits set. Example: P = 16 and N = 265 give 1, 8 and 256 cycles.
- R3: A request with N < 49 raises `cfgInvalid` in the same cycle, and after the current period ends no further `divPulse` is produced while the request stays illegal.
- R4: With P = 16, a request with N > 1023 is illegal because C does not fit in 6 bits, so `cfgInvalid` = 1. The same N with P = 32 is legal.
- R5: `divPulse` is high for exactly one input cycle, and that cycle is the last cycle of the period.
- R6: A change of `nReq` or `presSel` during a period does not change the length of that period. The new value applies from the next period.
- R7: When A = 0 or B = 0, the corresponding phase takes no cycles: no cycle shows its `modCtrl` code and the period is still exactly N.
- R8: While `rst` is high, and on the cycle after it, `divPulse` = 0 and `modCtrl` = 2'b00. The first clock edge after release with a legal request captures that request. The first pulse is visible after the N-th edge, counting the capture edge as the first.
- R9: From the stopped state, the first edge that sees a legal request captures it, and the first pulse follows after N edges counted as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| nReq | input | 11 | Requested total division ratio N |
| presSel | input | 1 | Prescaler base: 0 selects 16, 1 selects 32 |
| divPulse | output | 1 | One-cycle pulse per completed period |
| modCtrl | output | 2 | Modulus control: 01 extend by one, 10 extend by four, 00 base |
| cfgInvalid | output | 1 | High while the requested ratio is illegal |

## Verification
The bench counts the cycles that each `modCtrl` code occupies within one period. This exposes a wrong decomposition of N, and it exposes a zero-valued A or B phase that still takes a cycle. The period would then grow by one, or the cycles would land in the wrong phase.

Some tests change the request in the middle of a period. A divider that loads its counters early would end that period at the new length instead of the old one. Another test turns the request illegal during a period. A design that drops the running period, or that keeps pulsing on a stale setting, would miss the final pulse or show extra pulses.

The bench also probes the legality limits: N = 49, N = 48, and N = 1023 against N = 1024 for each prescaler base. An off-by-one comparison or an unchecked C overflow would flag these cases wrongly.

// File: rtl/qm_pkg.sv
`timescale 1ns/1ps
package qm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_A    = 2'd1,
    PH_B    = 2'd2,
    PH_C    = 2'd3
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic stepA;
    logic stepB;
    logic stepC;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic newValid;
    logic newAZero;
    logic newBZero;
    logic bLoadZero;
    logic aLast;
    logic bLast;
    logic cLast;
    logic quadEnd;
    logic preEnd;
  } status_t;

  localparam logic [1:0] MOD_BASE = 2'b00;
  localparam logic [1:0] MOD_EXT1 = 2'b01;
  localparam logic [1:0] MOD_EXT4 = 2'b10;

endpackage

// File: rtl/qm_split.sv
`timescale 1ns/1ps
// Splits a total ratio into C/B/A loads and judges its legality.
module qm_split #(
  parameter int N_W   = 11,
  parameter int C_W   = 6,
  parameter int B_W   = 3,
  parameter int A_W   = 2,
  parameter int N_MIN = 49
) (
  input  logic [N_W-1:0] nReq,
  input  logic           presSel,
  output logic [C_W-1:0] cVal,
  output logic [B_W-1:0] bVal,
  output logic [A_W-1:0] aVal,
  output logic           valid
);
  localparam int SH_LO = A_W + 2;  // base 16
  localparam int SH_HI = A_W + 3;  // base 32

  logic [N_W-1:0] cWide;
  logic [N_W-1:0] rem;
  logic [N_W-1:0] bWide;

  always_comb begin
    cWide = presSel ? (nReq >> SH_HI) : (nReq >> SH_LO);
    rem   = nReq - (presSel ? (cWide << SH_HI) : (cWide << SH_LO));
    bWide = rem >> A_W;
    aVal  = rem[A_W-1:0];
    bVal  = bWide[B_W-1:0];
    cVal  = cWide[C_W-1:0];
    valid = (nReq >= N_W'(N_MIN)) && ((cWide >> C_W) == '0) && ((bWide >> B_W) == '0);
  end
endmodule

// File: rtl/qm_datapath.sv
`timescale 1ns/1ps
module qm_datapath
  import qm_pkg::*;
#(
  parameter int N_W   = 11,
  parameter int C_W   = 6,
  parameter int B_W   = 3,
  parameter int A_W   = 2,
  parameter int N_MIN = 49
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] nReq,
  input  logic           presSel,
  input  strobe_t        stb,
  output status_t        st
);
  localparam int PRE_W = A_W + 3;
  localparam logic [PRE_W-1:0] PRE_MAX_LO = PRE_W'((1 << (A_W + 2)) - 1);
  localparam logic [PRE_W-1:0] PRE_MAX_HI = PRE_W'((1 << (A_W + 3)) - 1);
  localparam logic [PRE_W-1:0] QUAD_MAX   = PRE_W'((1 << A_W) - 1);

  logic [C_W-1:0]   cVal, cCnt;
  logic [B_W-1:0]   bVal, bCnt;
  logic [A_W-1:0]   aVal, aCnt;
  logic [PRE_W-1:0] preCnt;
  logic             pSelR;
  logic             newValid;

  qm_split #(.N_W(N_W), .C_W(C_W), .B_W(B_W), .A_W(A_W), .N_MIN(N_MIN)) i_split (
    .nReq(nReq), .presSel(presSel),
    .cVal(cVal), .bVal(bVal), .aVal(aVal), .valid(newValid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      aCnt   <= '0;
      bCnt   <= '0;
      cCnt   <= '0;
      preCnt <= '0;
      pSelR  <= 1'b0;
    end else if (stb.capture) begin
      aCnt   <= aVal;
      bCnt   <= bVal;
      cCnt   <= cVal;
      pSelR  <= presSel;
      preCnt <= '0;
    end else begin
      if (stb.stepA) aCnt <= aCnt - 1'b1;
      if (stb.stepB) begin
        if (preCnt == QUAD_MAX) begin
          preCnt <= '0;
          bCnt   <= bCnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      if (stb.stepC) begin
        if (st.preEnd) begin
          preCnt <= '0;
          cCnt   <= cCnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.newValid  = newValid;
    st.newAZero  = (aVal == '0);
    st.newBZero  = (bVal == '0);
    st.bLoadZero = (bCnt == '0);
    st.aLast     = (aCnt == A_W'(1));
    st.bLast     = (bCnt == B_W'(1));
    st.cLast     = (cCnt == C_W'(1));
    st.quadEnd   = (preCnt == QUAD_MAX);
    st.preEnd    = pSelR ? (preCnt == PRE_MAX_HI) : (preCnt == PRE_MAX_LO);
  end
endmodule

// File: rtl/qm_control.sv
`timescale 1ns/1ps
module qm_control
  import qm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  status_t st,
  output strobe_t stb,
  output logic    divPulse,
  output logic [1:0] modCtrl
);
  phase_t phase, phaseNxt, startPh;

  always_comb begin
    if (!st.newAZero)      startPh = PH_A;
    else if (!st.newBZero) startPh = PH_B;
    else                   startPh = PH_C;
  end

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    case (phase)
      PH_IDLE: begin
        if (st.newValid) begin
          stb.capture = 1'b1;
          phaseNxt    = startPh;
        end
      end
      PH_A: begin
        stb.stepA = 1'b1;
        if (st.aLast) phaseNxt = st.bLoadZero ? PH_C : PH_B;
      end
      PH_B: begin
        stb.stepB = 1'b1;
        if (st.quadEnd && st.bLast) phaseNxt = PH_C;
      end
      PH_C: begin
        stb.stepC = 1'b1;
        if (st.preEnd && st.cLast) begin
          if (st.newValid) begin
            stb.capture = 1'b1;
            phaseNxt    = startPh;
          end else begin
            phaseNxt = PH_IDLE;
          end
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNxt;
  end

  always_comb begin
    divPulse = (phase == PH_C) && st.preEnd && st.cLast;
    case (phase)
      PH_A:    modCtrl = MOD_EXT1;
      PH_B:    modCtrl = MOD_EXT4;
      default: modCtrl = MOD_BASE;
    endcase
  end
endmodule

// File: rtl/qm_divider.sv
`timescale 1ns/1ps
module qm_divider
  import qm_pkg::*;
#(
  parameter int N_W   = 11,
  parameter int C_W   = 6,
  parameter int B_W   = 3,
  parameter int A_W   = 2,
  parameter int N_MIN = 49
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] nReq,
  input  logic           presSel,
  output logic           divPulse,
  output logic [1:0]     modCtrl,
  output logic           cfgInvalid
);
  strobe_t strobes;
  status_t status;
  logic    captureStb;

  qm_datapath #(.N_W(N_W), .C_W(C_W), .B_W(B_W), .A_W(A_W), .N_MIN(N_MIN)) i_datapath (
    .clk(clk), .rst(rst), .nReq(nReq), .presSel(presSel), .stb(strobes), .st(status)
  );

  qm_control i_control (
    .clk(clk), .rst(rst), .st(status), .stb(strobes),
    .divPulse(divPulse), .modCtrl(modCtrl)
  );

  assign cfgInvalid = !status.newValid;
  assign captureStb = strobes.capture;
endmodule

// File: rtl/qm_checker.sv
`timescale 1ns/1ps
module qm_checker #(
  parameter int N_W   = 11,
  parameter int N_MIN = 49
) (
  input logic           clk,
  input logic           rst,
  input logic [N_W-1:0] nReq,
  input logic           divPulse,
  input logic [1:0]     modCtrl,
  input logic           cfgInvalid,
  input logic           captureStb
);
  logic [N_W:0] cnt;
  logic [N_W:0] expN;
  logic         armed;
  logic         running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expN    <= '0;
      armed   <= 1'b0;
      running <= 1'b0;
    end else begin
      if (captureStb) begin
        cnt     <= (N_W+1)'(1);
        expN    <= {1'b0, nReq};
        armed   <= 1'b1;
        running <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (divPulse) running <= 1'b0;
      end
    end
  end

  // R1: pulse lands exactly N cycles after the capture
  assert_period_R1: assert property (@(posedge clk) disable iff (rst)
    divPulse |-> (armed && cnt == expN));

  // R2: modulus lines never both set
  assert_mod_code_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(modCtrl));

  // R3: low ratios are flagged
  assert_low_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (nReq < N_W'(N_MIN)) |-> cfgInvalid);

  // R5: pulse is one cycle wide
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R6: while a period runs, capture only on its last cycle
  assert_boundary_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (captureStb && running) |-> divPulse);

  // R8: outputs quiet after a reset edge
  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(rst) |-> (!divPulse && modCtrl == 2'b00));
endmodule

bind qm_divider qm_checker #(.N_W(N_W), .N_MIN(N_MIN)) i_qm_checker (
  .clk(clk), .rst(rst), .nReq(nReq), .divPulse(divPulse),
  .modCtrl(modCtrl), .cfgInvalid(cfgInvalid), .captureStb(captureStb)
);

// File: tb/test_qm_divider.sv
`timescale 1ns/1ps
module test_qm_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] nReq = 11'd100;
  logic        presSel = 1'b0;
  logic        divPulse;
  logic [1:0]  modCtrl;
  logic        cfgInvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qm_divider i_qm_divider (
    .clk(clk), .rst(rst), .nReq(nReq), .presSel(presSel),
    .divPulse(divPulse), .modCtrl(modCtrl), .cfgInvalid(cfgInvalid)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startCfg(int n, bit p);
    @(negedge clk);
    rst = 1'b1; nReq = 11'(n); presSel = p;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitPulse(output int k, input int lim);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!divPulse && k < lim);
  endtask

  task automatic profile(int n, bit p, int ea, int eb, int ec, string req);
    int ca, cb, cc, k;
    ca = 0; cb = 0; cc = 0; k = 0;
    startCfg(n, p);
    while (k < 5000) begin
      @(negedge clk);
      k++;
      if (modCtrl == 2'b01) ca++;
      else if (modCtrl == 2'b10) cb++;
      else cc++;
      if (divPulse) break;
    end
    check("R8", $sformatf("first pulse edge N=%0d", n), k, n);
    check(req, "ext1 cycles", ca, ea);
    check(req, "ext4 cycles", cb, eb);
    check(req, "base cycles", cc, ec);
    @(negedge clk);
    check("R5", "pulse width", int'(divPulse), 0);
  endtask

  task automatic intervals(int n, bit p, int periods);
    int k;
    startCfg(n, p);
    waitPulse(k, 5000);
    for (int i = 0; i < periods; i++) begin
      waitPulse(k, 5000);
      check("R1", $sformatf("gap N=%0d P=%0d", n, p ? 32 : 16), k, n);
    end
  endtask

  task automatic resetTest();
    int k;
    @(negedge clk);
    rst = 1'b1;
    check("R8", "pulse in reset", int'(divPulse), 0);
    check("R8", "modCtrl in reset", int'(modCtrl), 0);
    startCfg(100, 1'b0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8", "pulse after reset edge", int'(divPulse), 0);
    check("R8", "modCtrl after reset edge", int'(modCtrl), 0);
    rst = 1'b0;
    waitPulse(k, 5000);
    check("R8", "restart first pulse", k, 100);
  endtask

  task automatic midChange();
    int k;
    startCfg(100, 1'b0);
    repeat (10) @(negedge clk);
    nReq = 11'd60;
    waitPulse(k, 5000);
    check("R6", "old period kept", k + 10, 100);
    waitPulse(k, 5000);
    check("R6", "new period used", k, 60);
    repeat (5) @(negedge clk);
    presSel = 1'b1; nReq = 11'd200;
    waitPulse(k, 5000);
    check("R6", "kept across base change", k + 5, 60);
    waitPulse(k, 5000);
    check("R6", "new base period", k, 200);
  endtask

  task automatic invalidTest();
    int k, pulses, busy;
    startCfg(48, 1'b0);
    check("R3", "flag at 48", int'(cfgInvalid), 1);
    pulses = 0; busy = 0;
    repeat (300) begin
      @(negedge clk);
      if (divPulse) pulses++;
      if (modCtrl != 2'b00) busy++;
    end
    check("R3", "pulses while illegal", pulses, 0);
    check("R3", "modCtrl active while illegal", busy, 0);
    nReq = 11'd49;
    #1;
    check("R3", "flag at 49", int'(cfgInvalid), 0);
    nReq = 11'd70;
    waitPulse(k, 5000);
    check("R9", "recovery first pulse", k, 70);
    nReq = 11'd1024; presSel = 1'b0;
    #1;
    check("R4", "1024 base16 flagged", int'(cfgInvalid), 1);
    presSel = 1'b1;
    #1;
    check("R4", "1024 base32 legal", int'(cfgInvalid), 0);
    nReq = 11'd1023; presSel = 1'b0;
    #1;
    check("R4", "1023 base16 legal", int'(cfgInvalid), 0);
    startCfg(60, 1'b0);
    repeat (5) @(negedge clk);
    nReq = 11'd10;
    waitPulse(k, 5000);
    check("R3", "running period finishes", k + 5, 60);
    pulses = 0;
    repeat (200) begin
      @(negedge clk);
      if (divPulse) pulses++;
    end
    check("R3", "stopped after illegal", pulses, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    resetTest();
    profile(265, 1'b0, 1, 8, 256, "R2");
    profile(49, 1'b0, 1, 0, 48, "R7");
    profile(64, 1'b1, 0, 0, 64, "R7");
    profile(100, 1'b0, 0, 4, 96, "R7");
    profile(2047, 1'b1, 3, 28, 2016, "R2");
    profile(1023, 1'b0, 3, 12, 1008, "R2");
    intervals(265, 1'b0, 3);
    intervals(150, 1'b1, 3);
    midChange();
    invalidTest();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule